// File: doc/BRIEF.md
# Fixed Gain Scaler with Signed-Digit Shift-Add Multiplier

This block multiplies each decimated sample by a constant gain a little above one, so that a signal whose peak sits below full scale (the largest stable input of the modulator in front is about 0.81 of full scale) is stretched back toward full scale before droop equalization. The gain is 1/0.825, just under the reciprocal of that stable limit, so that a full-amplitude tone does not push later stages into overflow. It runs once per output sample at the decimated rate (40 MHz in the target chain) and is placed between the halfband decimator and the equalizer.

The constant is truncated to a fixed-point code at elaboration. The code is rewritten in canonical signed-digit form, which has the fewest nonzero digits and never two nonzero digits side by side. The multiply is then a chain of adders and subtractors. The chain is nested in Horner form: it starts at the lowest digit, and the partial sum shifts right by one place before each higher digit is added. Digits that are zero cost only wiring. The exact product is rounded to the nearest integer, clamped to the output range, and registered. Valid and data appear one clock after the input.

Top module: `csd_gain_scaler`

## Requirements
- R1: With default parameters, the gain code is 79437 with 16 fractional bits, that is floor(65536*1000/825). For every input x whose scaled value fits, out_data equals floor((x*79437 + 32768) / 65536).
- R2: Rounding is to the nearest integer, with ties resolved toward plus infinity. It is exact over the whole 16-bit input range, including the edges next to the clamp: x=27033 gives 32767 without clamping, and x=-27034 gives -32768 without clamping.
- R3: When the rounded value exceeds 32767, out_data is 32767. This applies for example to x=27034 and x=32767.
- R4: When the rounded value is below -32768, out_data is -32768. This applies for example to x=-27035 and x=-32768.
- R5: out_valid equals in_valid delayed by exactly one clock. A sample presented with in_valid high appears on out_data one clock later.
- R6: While in_valid is low, out_data keeps its previous value whatever in_data carries.
- R7: While rst_n is low, out_valid and out_data are both zero.
- R8: For an accepted sample, the output has the sign of the input, and its magnitude is at least that of the input. Zero gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_data holds a sample |
| in_data | input | IN_W (16) | Two's complement input sample |
| out_valid | output | 1 | High when out_data holds a new scaled sample |
| out_data | output | OUT_W (16) | Scaled, rounded and clamped two's complement sample |

## Verification
The properties assume that in_valid and in_data are known, two-valued levels at every rising edge once reset is released, and that the default shape holds: equal input and output widths and a gain above one. The sign and magnitude property depends on that gain. The stimulus is applied at falling edges only, so inputs are settled at every sampling edge. It keeps in_valid low during reset. It sweeps every input code once, and then uses idle gaps in which in_data carries unrelated values that must not disturb the held output.

// File: rtl/csd_scaler_pkg.sv
package csd_scaler_pkg;

   localparam int MAX_DIGITS = 64;

   // Fixed-point gain code: floor(num * 2^frac / den)
   function automatic longint gain_code(input longint num, input longint den, input int frac);
      return (num <<< frac) / den;
   endfunction

   // Canonical signed-digit expansion; sel_neg picks the mask of -1 digits,
   // otherwise the mask of +1 digits is returned.
   function automatic logic [MAX_DIGITS-1:0] csd_mask(input longint value, input bit sel_neg);
      logic [MAX_DIGITS-1:0] pos_m;
      logic [MAX_DIGITS-1:0] neg_m;
      longint v;
      pos_m = '0;
      neg_m = '0;
      v     = value;
      for (int i = 0; i < MAX_DIGITS; i++) begin
         if (v[0]) begin
            if (v[1]) begin
               neg_m[i] = 1'b1;
               v = v + 1;
            end else begin
               pos_m[i] = 1'b1;
               v = v - 1;
            end
         end
         v = v >>> 1;
      end
      return sel_neg ? neg_m : pos_m;
   endfunction

   function automatic int digit_count(input logic [MAX_DIGITS-1:0] m);
      int n;
      n = 0;
      for (int i = 0; i < MAX_DIGITS; i++) n += int'(m[i]);
      return n;
   endfunction

endpackage

// File: rtl/csd_horner_chain.sv
module csd_horner_chain #(
   parameter int IN_W = 16,
   parameter int NDIG = 19,
   parameter int AW   = IN_W + NDIG + 1,
   parameter logic [NDIG-1:0] POS_MASK = '0,
   parameter logic [NDIG-1:0] NEG_MASK = '0
) (
   input  logic signed [IN_W-1:0] x,
   output logic signed [AW-1:0]   prod
);

   // Pre-scaling the input by 2^(NDIG-1) means every right shift in the
   // LSB-first Horner nest drops only zero bits, so the product is exact.
   localparam int PRE_SHIFT = NDIG - 1;

   logic signed [AW-1:0] x_ext;
   logic signed [AW-1:0] term;
   logic signed [AW-1:0] stage [NDIG];

   assign x_ext = {{(AW-IN_W){x[IN_W-1]}}, x};
   assign term  = x_ext <<< PRE_SHIFT;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      logic signed [AW-1:0] base;
      if (i == 0) begin : g_first
         assign base = '0;
      end else begin : g_next
         assign base = stage[i-1] >>> 1;
      end

      if (POS_MASK[i]) begin : g_add
         assign stage[i] = base + term;
      end else if (NEG_MASK[i]) begin : g_sub
         assign stage[i] = base - term;
      end else begin : g_wire
         assign stage[i] = base;
      end
   end

   assign prod = stage[NDIG-1];

endmodule

// File: rtl/round_clamp.sv
module round_clamp #(
   parameter int AW            = 36,
   parameter int FRAC_W        = 16,
   parameter int OUT_W         = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic signed [AW-1:0]    prod,
   output logic signed [OUT_W-1:0] y
);

   localparam logic signed [AW-1:0] OUT_MAX = AW'((longint'(1) <<< (OUT_W-1)) - 1);
   localparam logic signed [AW-1:0] OUT_MIN = -AW'(longint'(1) <<< (OUT_W-1));
   localparam logic signed [AW-1:0] HALF    = AW'(longint'(1) <<< (FRAC_W-1));

   logic signed [AW-1:0] biased;
   logic signed [AW-1:0] whole;

   if (ROUND_NEAREST) begin : g_nearest
      assign biased = prod + HALF;
   end else begin : g_floor
      assign biased = prod;
   end

   assign whole = biased >>> FRAC_W;

   always_comb begin
      if (whole > OUT_MAX)      y = OUT_MAX[OUT_W-1:0];
      else if (whole < OUT_MIN) y = OUT_MIN[OUT_W-1:0];
      else                      y = whole[OUT_W-1:0];
   end

endmodule

// File: rtl/csd_gain_scaler.sv
module csd_gain_scaler #(
   parameter int     IN_W          = 16,
   parameter int     OUT_W         = 16,
   parameter int     FRAC_W        = 16,
   parameter longint GAIN_NUM      = 1000,
   parameter longint GAIN_DEN      = 825,
   parameter bit     ROUND_NEAREST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_data
);
   import csd_scaler_pkg::*;

   localparam longint GAIN_Q = gain_code(GAIN_NUM, GAIN_DEN, FRAC_W);
   localparam int     NDIG   = FRAC_W + 3;
   localparam int     AW     = IN_W + NDIG + 1;
   localparam logic [MAX_DIGITS-1:0] POS_FULL = csd_mask(GAIN_Q, 1'b0);
   localparam logic [MAX_DIGITS-1:0] NEG_FULL = csd_mask(GAIN_Q, 1'b1);
   localparam logic [NDIG-1:0] POS_MASK = POS_FULL[NDIG-1:0];
   localparam logic [NDIG-1:0] NEG_MASK = NEG_FULL[NDIG-1:0];

   if (IN_W < 2 || OUT_W < 2 || FRAC_W < 1) begin : g_bad_width
      $error("csd_gain_scaler: widths too small");
   end
   if (NDIG > MAX_DIGITS || AW > 62) begin : g_bad_size
      $error("csd_gain_scaler: digit chain too wide");
   end
   if (GAIN_DEN <= 0 || GAIN_Q <= 0 || GAIN_Q >= (longint'(1) <<< (FRAC_W+1))) begin : g_bad_gain
      $error("csd_gain_scaler: gain must lie in (0, 2)");
   end
   if ((POS_FULL & NEG_FULL) != '0 || ((POS_FULL | NEG_FULL) & ((POS_FULL | NEG_FULL) >> 1)) != '0)
   begin : g_bad_csd
      $error("csd_gain_scaler: signed-digit form is not canonical");
   end

   logic signed [AW-1:0]    product;
   logic signed [OUT_W-1:0] scaled;

   csd_horner_chain #(
      .IN_W(IN_W), .NDIG(NDIG), .AW(AW),
      .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK)
   ) u_chain (
      .x(in_data),
      .prod(product)
   );

   round_clamp #(
      .AW(AW), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_round (
      .prod(product),
      .y(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= scaled;
      end
   end

endmodule

// File: rtl/csd_gain_scaler_chk.sv
module csd_gain_scaler_chk #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic signed [IN_W-1:0]  in_data,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_data
);

   localparam logic signed [IN_W-1:0]  IN_MAX  = {1'b0, {(IN_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [IN_W-1:0]  IN_MIN  = {1'b1, {(IN_W-1){1'b0}}};
   localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid) || !$past(rst_n));

   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_pos_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data >= 0) |=> (out_data >= 0 && OUT_W'(out_data) >= OUT_W'($past(in_data))));

   assert_neg_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data < 0) |=> (out_data < 0 && out_data <= OUT_W'($past(in_data))));

   assert_clamp_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == IN_MAX) |=> out_data == OUT_MAX);

   assert_clamp_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == IN_MIN) |=> out_data == OUT_MIN);

endmodule

bind csd_gain_scaler csd_gain_scaler_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_csd_gain_scaler.sv
module tb_csd_gain_scaler;

   localparam longint GQ     = (longint'(1000) <<< 16) / 825;
   localparam int     WD_CYC = 200000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   csd_gain_scaler dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic signed [15:0] expect_of(input int x);
      longint p;
      p = (longint'(x) * GQ + 32768) >>> 16;
      if (p > 32767)  p = 32767;
      if (p < -32768) p = -32768;
      return p[15:0];
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int x, input string req);
      in_valid = 1'b1;
      in_data  = 16'(x);
      @(negedge clk);
      check(req, longint'(out_data), longint'(expect_of(x)));
      check("R5 valid", longint'(out_valid), 1);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      in_data = 16'sd1234;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 out_valid", longint'(out_valid), 0);
      check("R7 out_data", longint'(out_data), 0);
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      check("R5 idle after reset", longint'(out_valid), 0);

      // R1/R2/R3/R4: every input code
      for (int v = -32768; v < 32768; v++) push(v, "R1 sweep");

      // R2 edges next to the clamp, R3/R4 clamp points
      push(27033, "R2 top edge");
      check("R2 top edge value", longint'(out_data), 32767);
      push(-27034, "R2 bottom edge");
      check("R2 bottom edge value", longint'(out_data), -32768);
      push(27034, "R3 clamp");
      check("R3 clamp value", longint'(out_data), 32767);
      push(32767, "R3 full scale");
      push(-27035, "R4 clamp");
      check("R4 clamp value", longint'(out_data), -32768);
      push(-32768, "R4 full scale");

      // R8: small values keep sign and do not shrink
      push(0, "R8 zero");
      check("R8 zero value", longint'(out_data), 0);
      push(1, "R8 plus one");
      check("R8 plus one value", longint'(out_data), 1);
      push(-1, "R8 minus one");
      check("R8 minus one value", longint'(out_data), -1);
      push(100, "R8 hundred");
      check("R8 hundred value", longint'(out_data), 121);

      // R6: idle cycles with changing data hold the last output
      push(1000, "R6 setup");
      for (int k = 0; k < 8; k++) begin
         in_valid = 1'b0;
         in_data  = 16'(-5000 + k * 777);
         @(negedge clk);
         check("R6 hold", longint'(out_data), longint'(expect_of(1000)));
         check("R5 low", longint'(out_valid), 0);
      end

      // R5: alternating valid pattern
      for (int k = 0; k < 20; k++) begin
         if (k % 3 == 0) begin
            in_valid = 1'b0;
            in_data  = 16'(k * 31);
            @(negedge clk);
            check("R5 gap", longint'(out_valid), 0);
         end else begin
            push(k * 1500 - 14000, "R5 burst");
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule